// File: doc/BRIEF.md
# SPI Slave Configuration Port with Key Activation

This block is the serial front end of a configuration-logic controller. An external SPI master clocks bytes into it over a mode 0 link (clock idles low, data sampled on the rising edge). The block presents those bytes to the configuration logic as an opcode followed by data bytes. In the same transaction it shifts response bytes, taken from a parallel input, back out on the serial output.

The port starts out inactive after power-on reset and honours no command. To open it, the master must shift in a fixed 32-bit key while the active-low request pin is held low. The whole key must arrive in one chip-select transaction and within a bounded number of system-clock cycles after reset. A wrong key or a late key closes the port until the next power-on reset. Once the port is open it stays open. The first byte of each later transaction is decoded as an opcode, and the refresh opcode also produces a dedicated pulse that tells the configuration logic to reload its working image from non-volatile storage.

All SPI pins and the request pin are sampled by an oversampling system clock through two-flop synchronisers. Serial clock edges are found as transitions of the synchronised clock. The serial clock must therefore run well below a quarter of the system clock rate.

Top module: `spi_cfg_port`

## Requirements
- R1: After a synchronous power-on reset (`rst_n` low), `active` is 0, `miso_oe` is 0, and `cmd_valid`, `byte_valid` and `refresh_pulse` are 0.
- R2: While `ss_n` is low, one bit of `mosi` is taken on each rising edge of `sck`, most significant bit first. Every eighth bit completes a received byte.
- R3: The response shift register is loaded from `tx_data` while `ss_n` is high and again at each byte boundary. Its most significant bit is placed on `miso` first, and the register advances one bit after each falling edge of `sck` that falls inside a byte. The master can therefore read each bit on the following rising edge.
- R4: `miso_oe` is 0 and `miso` is high impedance whenever `ss_n` is high or the port is not active.
- R5: The port becomes active only when the bytes of one transaction begin with the 32-bit parameter `KEY` (default 32'h9E371BD4), sent MSB first. Before that, no `cmd_valid`, `byte_valid` or `refresh_pulse` is produced, and the bytes that follow the key in the activating transaction are also ignored.
- R6: Key bytes received while `creq_n` is high do not count, and they clear any partially received key.
- R7: A completed 32-bit sequence that differs from `KEY` locks the port inactive, and a later correct key then has no effect until the next reset.
- R8: If the key is not complete within `WINDOW_CYCLES` clock cycles after reset, the port locks inactive until the next reset.
- R9: Once active, the first byte of each transaction appears on `cmd_opcode` with a one-cycle `cmd_valid` pulse. Each further byte appears on `rx_byte` with a one-cycle `byte_valid` pulse. The two strobes are never high together.
- R10: When an opcode equals `REFRESH_OP` (default 8'h79), `refresh_pulse` is high for one cycle, in the same cycle as `cmd_valid`.
- R11: Raising `ss_n` discards a partially received byte, and the next transaction restarts at the opcode.
- R12: An active port stays active, whatever happens on `creq_n` or the SPI pins, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oversampling) clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| creq_n | input | 1 | Active-low request pin that must be held low during activation |
| sck | input | 1 | SPI serial clock from the master |
| mosi | input | 1 | SPI serial data from the master |
| ss_n | input | 1 | SPI active-low select |
| miso | output | 1 | SPI serial data to the master, high impedance when disabled |
| miso_oe | output | 1 | Output enable of `miso` |
| tx_data | input | 8 | Response byte loaded on selection and at each byte boundary |
| active | output | 1 | Port has been opened by a valid key |
| cmd_valid | output | 1 | One-cycle strobe for a new opcode |
| cmd_opcode | output | 8 | First byte of the current transaction |
| byte_valid | output | 1 | One-cycle strobe for a data byte |
| rx_byte | output | 8 | Latest data byte |
| refresh_pulse | output | 1 | One-cycle pulse on a refresh opcode |

## Verification
The embedded properties watch, on every cycle, the invariants of the state: an open port never closes and a locked port never reopens. They also check that strobes appear only on an open port, that the opcode and data strobes never coincide, that a refresh pulse always carries the refresh opcode, and that the bit counter clears while deselected. Whether a key is accepted or rejected depends on the order of events: a key sent with the request pin high, a key after a wrong one, a key after the window has expired, or trailing bytes in the activating transaction. The same is true of the serial timing of the response bytes and of partial-byte recovery. Only the bench's scenarios can show these, by comparing the received bytes and strobe counts with values computed from the requirements.

// File: rtl/spi_cfg_pkg.sv
// Shared types and constants for the SPI configuration port.
// Assumes: bytes are eight bits wide throughout the port.
package spi_cfg_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ACT_WAIT = 2'd0,
        ACT_ON   = 2'd1,
        ACT_LOCK = 2'd2
    } act_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
// Two-flop synchroniser bank for asynchronous pins.
// Assumes: pins change slowly relative to clk; each bit is synchronised on its own,
// with a per-bit reset value so idle-high pins start deasserted.
module spi_pin_sync #(
    parameter int          N       = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_in,
    output logic [N-1:0] pins_s
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic meta_q;
        logic sync_q;

        // Two-stage capture of one asynchronous pin.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                sync_q <= RST_VAL[g];
            end else begin
                meta_q <= pins_in[g];
                sync_q <= meta_q;
            end
        end

        assign pins_s[g] = sync_q;
    end
endmodule

// File: rtl/spi_bit_engine.sv
// Serial bit engine: assembles received bytes and shifts response bytes, SPI mode 0.
// Assumes: synchronised inputs; sck at most a quarter of clk; ss_s high resets the byte.
module spi_bit_engine
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              ss_s,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_data,
    output logic              miso_d
);
    localparam int BC_W = $clog2(BYTE_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);

    logic              sck_q;
    logic              sck_rise;
    logic              sck_fall;
    logic [BC_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;

    assign sck_rise = sck_s & ~sck_q;
    assign sck_fall = ~sck_s & sck_q;
    assign miso_d   = tx_sh[BYTE_W-1];

    // Edge history, receive shift, bit count and response shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q     <= 1'b0;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            rx_data   <= '0;
            tx_sh     <= '0;
            byte_done <= 1'b0;
        end else begin
            sck_q     <= sck_s;
            byte_done <= 1'b0;
            if (ss_s) begin
                bit_cnt <= '0;
                tx_sh   <= tx_data;
            end else begin
                if (sck_rise) begin
                    rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
                    bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        byte_done <= 1'b1;
                        rx_data   <= {rx_sh[BYTE_W-2:0], mosi_s};
                    end
                end
                if (sck_fall && bit_cnt != '0) begin
                    tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
                if (byte_done) begin
                    tx_sh <= tx_data;
                end
            end
        end
    end

    // R11
    bitcnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |=> (bit_cnt == '0));

    // R2
    done_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(sck_rise) && !$past(ss_s));
endmodule

// File: rtl/spi_activation.sv
// Activation gate: compares the first bytes of a transaction against a key
// within a cycle window after reset; a mismatch or timeout locks the port.
// Assumes: KEY_W is a multiple of 8 and at least 16; creq_s is synchronised active-low.
module spi_activation
    import spi_cfg_pkg::*;
#(
    parameter int          KEY_W         = 32,
    parameter logic [KEY_W-1:0] KEY      = 32'h9E37_1BD4,
    parameter int          WINDOW_CYCLES = 950_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_s,
    input  logic              creq_s,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              active
);
    localparam int KEY_BYTES = KEY_W / BYTE_W;
    localparam int KC_W      = $clog2(KEY_BYTES) + 1;
    localparam int WIN_W     = $clog2(WINDOW_CYCLES + 1);
    localparam logic [KC_W-1:0]  KC_LAST  = KC_W'(KEY_BYTES - 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_CYCLES - 1);

    act_state_e       state;
    logic [WIN_W-1:0] win_cnt;
    logic [KC_W-1:0]  key_cnt;
    logic [KEY_W-1:0] key_sh;
    logic [KEY_W-1:0] key_next;

    assign key_next = {key_sh[KEY_W-BYTE_W-1:0], rx_data};
    assign active   = (state == ACT_ON);

    // Window timer, key collection and the wait/on/lock decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ACT_WAIT;
            win_cnt <= '0;
            key_cnt <= '0;
            key_sh  <= '0;
        end else if (state == ACT_WAIT) begin
            win_cnt <= win_cnt + 1'b1;
            if (win_cnt == WIN_LAST) begin
                state <= ACT_LOCK;
            end else if (ss_s || creq_s) begin
                key_cnt <= '0;
            end else if (byte_done) begin
                key_sh <= key_next;
                if (key_cnt == KC_LAST) begin
                    key_cnt <= '0;
                    state   <= (key_next == KEY) ? ACT_ON : ACT_LOCK;
                end else begin
                    key_cnt <= key_cnt + 1'b1;
                end
            end
        end
    end

    // R12
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ACT_ON) |=> (state == ACT_ON));

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ACT_LOCK) |=> (state == ACT_LOCK));
endmodule

// File: rtl/spi_cmd_frame.sv
// Command framing: first byte of an enabled transaction is the opcode, the rest are data.
// Assumes: a transaction is enabled only if the port was active when it began.
module spi_cmd_frame
    import spi_cfg_pkg::*;
#(
    parameter logic [BYTE_W-1:0] REFRESH_OP = 8'h79
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_s,
    input  logic              active,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_opcode,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              refresh_pulse
);
    logic txn_en;
    logic first_q;

    // Transaction enable, opcode/data split and refresh decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txn_en        <= 1'b0;
            first_q       <= 1'b1;
            cmd_valid     <= 1'b0;
            cmd_opcode    <= '0;
            byte_valid    <= 1'b0;
            rx_byte       <= '0;
            refresh_pulse <= 1'b0;
        end else begin
            cmd_valid     <= 1'b0;
            byte_valid    <= 1'b0;
            refresh_pulse <= 1'b0;
            if (ss_s) begin
                txn_en  <= active;
                first_q <= 1'b1;
            end else if (byte_done && txn_en) begin
                if (first_q) begin
                    first_q       <= 1'b0;
                    cmd_valid     <= 1'b1;
                    cmd_opcode    <= rx_data;
                    refresh_pulse <= (rx_data == REFRESH_OP);
                end else begin
                    byte_valid <= 1'b1;
                    rx_byte    <= rx_data;
                end
            end
        end
    end

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && byte_valid));

    // R10
    refresh_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_pulse |-> (cmd_valid && cmd_opcode == REFRESH_OP));
endmodule

// File: rtl/spi_cfg_port.sv
// SPI slave configuration port with key activation (top level).
// Assumes: mode 0 only; clk oversamples sck by at least four; rst_n is the power-on reset.
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter int               KEY_W         = 32,
    parameter logic [KEY_W-1:0] KEY           = 32'h9E37_1BD4,
    parameter int               WINDOW_CYCLES = 950_000,
    parameter logic [7:0]       REFRESH_OP    = 8'h79
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       creq_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic       ss_n,
    output logic       miso,
    output logic       miso_oe,
    input  logic [7:0] tx_data,
    output logic       active,
    output logic       cmd_valid,
    output logic [7:0] cmd_opcode,
    output logic       byte_valid,
    output logic [7:0] rx_byte,
    output logic       refresh_pulse
);
    logic [3:0]        pins_s;
    logic              sck_s;
    logic              mosi_s;
    logic              ss_s;
    logic              creq_s;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_data;
    logic              miso_d;

    spi_pin_sync #(
        .N       (4),
        .RST_VAL (4'b1100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_in ({creq_n, ss_n, mosi, sck}),
        .pins_s  (pins_s)
    );

    assign sck_s  = pins_s[0];
    assign mosi_s = pins_s[1];
    assign ss_s   = pins_s[2];
    assign creq_s = pins_s[3];

    spi_bit_engine u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (sck_s),
        .mosi_s    (mosi_s),
        .ss_s      (ss_s),
        .tx_data   (tx_data),
        .byte_done (byte_done),
        .rx_data   (rx_data),
        .miso_d    (miso_d)
    );

    spi_activation #(
        .KEY_W         (KEY_W),
        .KEY           (KEY),
        .WINDOW_CYCLES (WINDOW_CYCLES)
    ) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .ss_s      (ss_s),
        .creq_s    (creq_s),
        .byte_done (byte_done),
        .rx_data   (rx_data),
        .active    (active)
    );

    spi_cmd_frame #(
        .REFRESH_OP (REFRESH_OP)
    ) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .ss_s          (ss_s),
        .active        (active),
        .byte_done     (byte_done),
        .rx_data       (rx_data),
        .cmd_valid     (cmd_valid),
        .cmd_opcode    (cmd_opcode),
        .byte_valid    (byte_valid),
        .rx_byte       (rx_byte),
        .refresh_pulse (refresh_pulse)
    );

    // Output driver: enabled only while selected on an open port.
    assign miso_oe = active & ~ss_s;
    assign miso    = miso_oe ? miso_d : 1'bz;

    // R5
    cmd_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || byte_valid) |-> active);
endmodule

// File: tb/spi_cfg_port_bench.sv
// Bench for spi_cfg_port: table-driven command traffic, then directed activation cases.
module spi_cfg_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WIN        = 4000;
    localparam logic [31:0] KEY_V = 32'h9E37_1BD4;
    localparam logic [7:0]  REF_V = 8'h79;

    // {opcode, data, tx_data, 7'b0, refresh_expected}
    localparam int NVEC = 5;
    localparam logic [31:0] VEC [NVEC] = '{
        32'h10_3C_A5_00,
        32'h79_00_5A_01,
        32'hFF_81_00_00,
        32'h00_FF_FF_00,
        32'h79_42_C3_01
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       creq_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       ss_n = 1'b1;
    wire        miso;
    logic       miso_oe;
    logic [7:0] tx_data = 8'h00;
    logic       active;
    logic       cmd_valid;
    logic [7:0] cmd_opcode;
    logic       byte_valid;
    logic [7:0] rx_byte;
    logic       refresh_pulse;

    int n_chk = 0;
    int n_err = 0;
    int n_cmd = 0;
    int n_byte = 0;
    int n_ref = 0;
    logic [7:0] last_op = 8'h00;
    logic [7:0] last_byte = 8'h00;

    spi_cfg_port #(
        .WINDOW_CYCLES (WIN)
    ) u_spi_cfg_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .creq_n        (creq_n),
        .sck           (sck),
        .mosi          (mosi),
        .ss_n          (ss_n),
        .miso          (miso),
        .miso_oe       (miso_oe),
        .tx_data       (tx_data),
        .active        (active),
        .cmd_valid     (cmd_valid),
        .cmd_opcode    (cmd_opcode),
        .byte_valid    (byte_valid),
        .rx_byte       (rx_byte),
        .refresh_pulse (refresh_pulse)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid)     begin n_cmd++;  last_op   = cmd_opcode; end
            if (byte_valid)    begin n_byte++; last_byte = rx_byte;    end
            if (refresh_pulse) n_ref++;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ss_n = 1'b1;
        sck = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // One select-low transaction of nbits bits, MSB first; returns bits read on miso.
    task automatic spi_txn(input logic [63:0] d, input int nbits,
                           output logic [63:0] rd, output logic oe_seen);
        rd = '0;
        oe_seen = 1'b0;
        @(negedge clk);
        ss_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = d[i];
            repeat (HALF) @(negedge clk);
            oe_seen = oe_seen | miso_oe;
            sck = 1'b1;
            rd = {rd[62:0], miso};
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        ss_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        logic        oe;
        int          c0;
        int          r0;

        do_reset();
        // R1: reset state
        check("R1 active", 64'(active), 64'd0);
        check("R1 miso_oe", 64'(miso_oe), 64'd0);
        check("R1 strobes", 64'({cmd_valid, byte_valid, refresh_pulse}), 64'd0);

        // R6: correct key while creq_n high does not activate
        creq_n = 1'b1;
        spi_txn({32'd0, KEY_V}, 32, rd, oe);
        check("R6 key with creq_n high", 64'(active), 64'd0);

        // R5/R4: command before activation is ignored and miso stays disabled
        creq_n = 1'b0;
        spi_txn({48'd0, REF_V, 8'h55}, 16, rd, oe);
        check("R5 no cmd before key", 64'(n_cmd + n_byte + n_ref), 64'd0);
        check("R4 oe before key", 64'(oe), 64'd0);

        // R7: wrong key locks, then correct key is refused
        spi_txn({32'd0, KEY_V ^ 32'h0000_0100}, 32, rd, oe);
        check("R7 wrong key", 64'(active), 64'd0);
        spi_txn({32'd0, KEY_V}, 32, rd, oe);
        check("R7 locked after wrong key", 64'(active), 64'd0);

        // R8: key after the window has expired is refused
        do_reset();
        repeat (WIN + 20) @(negedge clk);
        spi_txn({32'd0, KEY_V}, 32, rd, oe);
        check("R8 late key", 64'(active), 64'd0);

        // R5: correct key in time activates; trailing byte ignored
        do_reset();
        c0 = n_cmd;
        r0 = n_ref;
        spi_txn({24'd0, KEY_V, REF_V}, 40, rd, oe);
        check("R5 activated", 64'(active), 64'd1);
        check("R5 trailing byte ignored", 64'(n_cmd - c0 + n_ref - r0), 64'd0);
        check("R4 oe off when deselected", 64'(miso_oe), 64'd0);

        // R2/R3/R9/R10: table of command transactions
        for (int v = 0; v < NVEC; v++) begin
            int cb;
            int bb;
            int rb;
            cb = n_cmd;
            bb = n_byte;
            rb = n_ref;
            tx_data = VEC[v][15:8];
            spi_txn({48'd0, VEC[v][31:16]}, 16, rd, oe);
            check("R9 one opcode strobe", 64'(n_cmd - cb), 64'd1);
            check("R2 opcode value", 64'(last_op), 64'(VEC[v][31:24]));
            check("R9 one data strobe", 64'(n_byte - bb), 64'd1);
            check("R2 data value", 64'(last_byte), 64'(VEC[v][23:16]));
            check("R10 refresh count", 64'(n_ref - rb), 64'(VEC[v][0]));
            check("R3 response bytes", rd[15:0], {48'd0, VEC[v][15:8], VEC[v][15:8]});
        end

        // R9: three-byte transaction gives one opcode and two data bytes
        c0 = n_cmd;
        r0 = n_byte;
        tx_data = 8'h96;
        spi_txn({40'd0, 8'h21, 8'h34, 8'hE7}, 24, rd, oe);
        check("R9 multi opcode", 64'(n_cmd - c0), 64'd1);
        check("R9 multi data count", 64'(n_byte - r0), 64'd2);
        check("R9 last data", 64'(last_byte), 64'hE7);
        check("R3 three response bytes", rd[23:0], {40'd0, 24'h969696});

        // R11: a partial byte is discarded
        c0 = n_cmd;
        r0 = n_byte;
        spi_txn({59'd0, 5'b10101}, 5, rd, oe);
        check("R11 partial gives nothing", 64'(n_cmd - c0 + n_byte - r0), 64'd0);
        spi_txn({48'd0, 8'h22, 8'h11}, 16, rd, oe);
        check("R11 opcode after partial", 64'(last_op), 64'h22);
        check("R11 data after partial", 64'(last_byte), 64'h11);

        // R12: active persists with creq_n high and more traffic
        creq_n = 1'b1;
        spi_txn({32'd0, KEY_V ^ 32'hFFFF_FFFF}, 32, rd, oe);
        check("R12 still active", 64'(active), 64'd1);
        check("R4 oe while selected and active", 64'(oe), 64'd1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule